// File: doc/BRIEF.md
# Unaligned Read Data Realigner

This block sits on the read path between a wide bus-side data stream and a narrower user-side data stream. A command names where the wanted data starts inside the first bus word, as a byte offset, and how many bytes are wanted. The block drops the unwanted leading bytes of the first bus word. It then packs the remaining bytes, across bus beat boundaries, so that the first wanted byte lands in the least significant byte of the first user word. It emits exactly as many user words as the byte count needs.

Each command pulls exactly the number of bus beats that its offset and length span. Any bytes left over in the final beat are thrown away, so the next command starts from an empty buffer. Both streams use valid/ready handshakes. The block honours backpressure from the user side and applies backpressure to the bus side when it has no room. Address generation and bus responses are handled elsewhere.

Top module: `rd_realign`

## Requirements
- R1: During and directly after reset, `cmd_ready_o` is 1, while `bus_ready_o` and `usr_valid_o` are 0.
- R2: Bits [7:0] of the first user word of a command carry byte lane `cmd_ofs_i` of the first bus beat. Byte lane i of a bus word is bits [8*i+7:8*i].
- R3: Requested byte k, counted from 0 at the start byte, appears in user word k / (USR_W/8), at byte lane k mod (USR_W/8). The bytes continue in order across bus beat boundaries.
- R4: A command of N bytes produces exactly ceil(N / (USR_W/8)) user words, and no further ones.
- R5: A command with offset O and N > 0 bytes takes exactly ceil((O + N) / (AXI_W/8)) bus beats. No beat is taken before the command or after those beats.
- R6: Unused bytes of the last bus beat are dropped when a command ends. A following command is realigned as if it came directly after reset.
- R7: While `usr_valid_o` is 1 and `usr_ready_i` is 0, `usr_valid_o` stays 1 and `usr_data_o` does not change in the next cycle.
- R8: `cmd_ready_o` is 0 from the cycle after a command with N > 0 is accepted until its last user word is taken, and any command offered during that time is ignored. While `cmd_ready_o` is 1, both `bus_ready_o` and `usr_valid_o` are 0.
- R9: A command with N = 0 is accepted, takes no bus beat, produces no user word, and leaves `cmd_ready_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block is idle and takes a command |
| cmd_ofs_i | input | log2(AXI_W/8) | Byte offset of the first wanted byte inside the first bus word |
| cmd_bytes_i | input | SIZE_W | Number of wanted bytes |
| bus_data_i | input | AXI_W | Bus-side read data |
| bus_valid_i | input | 1 | Bus-side data valid |
| bus_ready_o | output | 1 | Block takes a bus beat |
| usr_data_o | output | USR_W | Right-aligned user data; bytes past the request are undefined |
| usr_valid_o | output | 1 | User word valid |
| usr_ready_i | input | 1 | User side takes the word |

## Verification
If the fill count or the shift offset is wrong inside the block, the bytes on `usr_data_o` come out rotated or repeated. This shows up on the first user word of the affected command, one cycle after the bus beat that brought the bytes in. If the byte counter or the beat counter is wrong, the block either takes one bus beat too many or too few, or stops with `cmd_ready_o` low. A leftover byte that is not flushed shows up as corrupted lanes in the first word of the next command. The directed scenarios use every start offset, odd lengths, single-byte requests and commands issued back to back, so each of these faults appears within one command.

// File: rtl/rd_realign_pkg.sv
// Package: shared helpers for the read data realigner.
// Assumes byte widths are powers of two so divisions reduce to shifts.
package rd_realign_pkg;

    localparam int BYTE_BITS = 8;

    // Number of wide words touched by a span starting at ofs and lasting nbytes.
    function automatic logic [31:0] span_words(input logic [31:0] ofs,
                                               input logic [31:0] nbytes,
                                               input int unsigned lg);
        logic [31:0] round;
        round = (32'd1 << lg) - 32'd1;
        return (ofs + nbytes + round) >> lg;
    endfunction

endpackage

// File: rtl/rd_realign_cmd.sv
// Module: command tracker for the realigner.
// Holds the bytes still owed to the user side, the bus beats still to take,
// the leading skip of the first beat, and a flag marking that first beat.
// Assumes no pop happens while idle (enforced by the top).
module rd_realign_cmd
    import rd_realign_pkg::*;
#(
    parameter int AXI_W  = 32,
    parameter int USR_W  = 16,
    parameter int SIZE_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid_i,
    input  logic [$clog2(AXI_W/8)-1:0]    cmd_ofs_i,
    input  logic [SIZE_W-1:0]             cmd_bytes_i,
    input  logic                          accept_i,
    input  logic                          pop_i,
    output logic                          cmd_ready_o,
    output logic [SIZE_W-1:0]             left_o,
    output logic [SIZE_W:0]               beats_o,
    output logic [$clog2(AXI_W/8)-1:0]    skip_o,
    output logic                          last_pop_o
);

    localparam int AXI_B  = AXI_W / BYTE_BITS;
    localparam int USR_B  = USR_W / BYTE_BITS;
    localparam int OFS_W  = $clog2(AXI_B);
    localparam int BEAT_W = SIZE_W + 1;

    logic [SIZE_W-1:0] left_q;
    logic [BEAT_W-1:0] beats_q;
    logic [OFS_W-1:0]  skip_q;
    logic              first_q;
    logic              take;
    logic [BEAT_W-1:0] beats_need;

    assign cmd_ready_o = (left_q == '0);
    assign take        = cmd_valid_i && cmd_ready_o && (cmd_bytes_i != '0);
    assign beats_need  = BEAT_W'(span_words(32'(cmd_ofs_i), 32'(cmd_bytes_i), OFS_W));
    assign last_pop_o  = pop_i && (left_q <= SIZE_W'(USR_B));
    assign left_o      = left_q;
    assign beats_o     = beats_q;
    assign skip_o      = first_q ? skip_q : '0;

    // Load a new command or count down bytes and beats as they move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            beats_q <= '0;
            skip_q  <= '0;
            first_q <= 1'b0;
        end else if (take) begin
            left_q  <= cmd_bytes_i;
            beats_q <= beats_need;
            skip_q  <= cmd_ofs_i;
            first_q <= 1'b1;
        end else begin
            if (accept_i) begin
                beats_q <= beats_q - BEAT_W'(1);
                first_q <= 1'b0;
            end
            if (pop_i) begin
                left_q <= (left_q > SIZE_W'(USR_B)) ? (left_q - SIZE_W'(USR_B)) : '0;
            end
        end
    end

endmodule

// File: rtl/rd_realign_pack.sv
// Module: byte holding register for the realigner.
// Keeps a right-aligned run of valid bytes; bytes at and above the fill level
// are always zero. A pop removes one user word from the bottom; an accept
// appends a bus beat, minus its skipped leading bytes, right above the
// remaining fill. A flush empties the register.
// Assumes accept is only raised when the fill after pop is below one user word.
module rd_realign_pack
    import rd_realign_pkg::*;
#(
    parameter int AXI_W = 32,
    parameter int USR_W = 16
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       pop_i,
    input  logic                                       accept_i,
    input  logic                                       flush_i,
    input  logic [AXI_W-1:0]                           bus_data_i,
    input  logic [$clog2(AXI_W/8)-1:0]                 skip_i,
    output logic [$clog2((AXI_W+USR_W)/8+1)-1:0]       fill_o,
    output logic [$clog2((AXI_W+USR_W)/8+1)-1:0]       fill_ap_o,
    output logic [USR_W-1:0]                           head_o
);

    localparam int AXI_B  = AXI_W / BYTE_BITS;
    localparam int USR_B  = USR_W / BYTE_BITS;
    localparam int BUF_B  = AXI_B + USR_B;
    localparam int BUF_W  = BUF_B * BYTE_BITS;
    localparam int FILL_W = $clog2(BUF_B + 1);

    logic [BUF_W-1:0]  hold_q;
    logic [BUF_W-1:0]  shifted;
    logic [BUF_W-1:0]  incoming;
    logic [BUF_W-1:0]  merged;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_ap;
    logic [FILL_W-1:0] fill_d;

    assign fill_ap   = pop_i ? (fill_q - FILL_W'(USR_B)) : fill_q;
    assign fill_o    = fill_q;
    assign fill_ap_o = fill_ap;
    assign head_o    = hold_q[USR_W-1:0];

    // Drop a popped word and append the trimmed incoming beat above what stays.
    always_comb begin
        shifted  = pop_i ? (hold_q >> USR_W) : hold_q;
        incoming = BUF_W'(bus_data_i >> {skip_i, 3'b000});
        merged   = shifted;
        fill_d   = fill_ap;
        if (accept_i) begin
            merged = shifted | (incoming << {fill_ap, 3'b000});
            fill_d = fill_ap + FILL_W'(AXI_B) - FILL_W'(skip_i);
        end
    end

    // Register the packed bytes and fill level; flush clears both.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            hold_q <= '0;
            fill_q <= '0;
        end else begin
            hold_q <= merged;
            fill_q <= fill_d;
        end
    end

endmodule

// File: rtl/rd_realign.sv
// Module: unaligned read data realigner (top).
// Takes a command (start byte offset within the first bus word, byte count),
// consumes the bus beats that span it, and emits right-aligned user words.
// Assumes AXI_W is a power-of-two multiple of USR_W, both whole bytes,
// and AXI_W of at least 16 bits.
module rd_realign
    import rd_realign_pkg::*;
#(
    parameter int AXI_W  = 32,
    parameter int USR_W  = 16,
    parameter int SIZE_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid_i,
    output logic                        cmd_ready_o,
    input  logic [$clog2(AXI_W/8)-1:0]  cmd_ofs_i,
    input  logic [SIZE_W-1:0]           cmd_bytes_i,
    input  logic [AXI_W-1:0]            bus_data_i,
    input  logic                        bus_valid_i,
    output logic                        bus_ready_o,
    output logic [USR_W-1:0]            usr_data_o,
    output logic                        usr_valid_o,
    input  logic                        usr_ready_i
);

    localparam int AXI_B  = AXI_W / BYTE_BITS;
    localparam int USR_B  = USR_W / BYTE_BITS;
    localparam int OFS_W  = $clog2(AXI_B);
    localparam int FILL_W = $clog2(AXI_B + USR_B + 1);

    logic [SIZE_W-1:0] left;
    logic [SIZE_W:0]   beats;
    logic [OFS_W-1:0]  skip;
    logic [FILL_W-1:0] fill;
    logic [FILL_W-1:0] fill_ap;
    logic              pop;
    logic              accept;
    logic              flush;
    logic              has_word;
    logic              covers_tail;

    // A word is ready once a full word is held or the held bytes cover the rest.
    assign has_word    = (fill >= FILL_W'(USR_B));
    assign covers_tail = ({{SIZE_W{1'b0}}, fill} >= {{FILL_W{1'b0}}, left});
    assign usr_valid_o = (left != '0) && (has_word || covers_tail);
    assign pop         = usr_valid_o && usr_ready_i;

    // Take a beat only while beats are owed and the register has room for one.
    assign bus_ready_o = (beats != '0) && (fill_ap < FILL_W'(USR_B));
    assign accept      = bus_valid_i && bus_ready_o;

    rd_realign_cmd #(
        .AXI_W (AXI_W),
        .USR_W (USR_W),
        .SIZE_W(SIZE_W)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid_i(cmd_valid_i),
        .cmd_ofs_i  (cmd_ofs_i),
        .cmd_bytes_i(cmd_bytes_i),
        .accept_i   (accept),
        .pop_i      (pop),
        .cmd_ready_o(cmd_ready_o),
        .left_o     (left),
        .beats_o    (beats),
        .skip_o     (skip),
        .last_pop_o (flush)
    );

    rd_realign_pack #(
        .AXI_W(AXI_W),
        .USR_W(USR_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_i     (pop),
        .accept_i  (accept),
        .flush_i   (flush),
        .bus_data_i(bus_data_i),
        .skip_i    (skip),
        .fill_o    (fill),
        .fill_ap_o (fill_ap),
        .head_o    (usr_data_o)
    );

endmodule

// File: rtl/rd_realign_chk.sv
// Module: protocol and count checker for the realigner, bound to the top.
// Tracks the words and beats each command should move, seen only at the ports.
module rd_realign_chk #(
    parameter int AXI_W  = 32,
    parameter int USR_W  = 16,
    parameter int SIZE_W = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_valid_i,
    input logic                        cmd_ready_o,
    input logic [$clog2(AXI_W/8)-1:0]  cmd_ofs_i,
    input logic [SIZE_W-1:0]           cmd_bytes_i,
    input logic                        bus_valid_i,
    input logic                        bus_ready_o,
    input logic [USR_W-1:0]            usr_data_o,
    input logic                        usr_valid_o,
    input logic                        usr_ready_i
);

    localparam int AXI_B = AXI_W / 8;
    localparam int USR_B = USR_W / 8;
    localparam int CNT_W = SIZE_W + 2;

    logic [CNT_W-1:0] exp_words_q, exp_beats_q, words_q, beats_q;

    // Capture the expected totals at command acceptance and count handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_words_q <= '0;
            exp_beats_q <= '0;
            words_q     <= '0;
            beats_q     <= '0;
        end else if (cmd_valid_i && cmd_ready_o && (cmd_bytes_i != '0)) begin
            exp_words_q <= CNT_W'((32'(cmd_bytes_i) + USR_B - 1) / USR_B);
            exp_beats_q <= CNT_W'((32'(cmd_ofs_i) + 32'(cmd_bytes_i) + AXI_B - 1) / AXI_B);
            words_q     <= '0;
            beats_q     <= '0;
        end else begin
            if (usr_valid_o && usr_ready_i) words_q <= words_q + CNT_W'(1);
            if (bus_valid_i && bus_ready_o) beats_q <= beats_q + CNT_W'(1);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready_o && !bus_ready_o && !usr_valid_o));

    // R7
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_valid_o && !usr_ready_i) |=> (usr_valid_o && $stable(usr_data_o)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> (!bus_ready_o && !usr_valid_o));

    // R4
    word_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready_o) |-> (words_q == exp_words_q));

    // R5
    beat_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready_o) |-> (beats_q == exp_beats_q));

endmodule

bind rd_realign rd_realign_chk #(
    .AXI_W (AXI_W),
    .USR_W (USR_W),
    .SIZE_W(SIZE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid_i(cmd_valid_i),
    .cmd_ready_o(cmd_ready_o),
    .cmd_ofs_i  (cmd_ofs_i),
    .cmd_bytes_i(cmd_bytes_i),
    .bus_valid_i(bus_valid_i),
    .bus_ready_o(bus_ready_o),
    .usr_data_o (usr_data_o),
    .usr_valid_o(usr_valid_o),
    .usr_ready_i(usr_ready_i)
);

// File: tb/rd_realign_tb.sv
`timescale 1ns/1ps
// Directed bench for the read data realigner; one task per scenario.
module rd_realign_tb;

    localparam int AXI_W  = 32;
    localparam int USR_W  = 16;
    localparam int SIZE_W = 12;
    localparam int AXI_B  = AXI_W / 8;
    localparam int USR_B  = USR_W / 8;
    localparam int OFS_W  = $clog2(AXI_B);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid_i = 1'b0;
    logic              cmd_ready_o;
    logic [OFS_W-1:0]  cmd_ofs_i = '0;
    logic [SIZE_W-1:0] cmd_bytes_i = '0;
    logic [AXI_W-1:0]  bus_data_i = '0;
    logic              bus_valid_i = 1'b0;
    logic              bus_ready_o;
    logic [USR_W-1:0]  usr_data_o;
    logic              usr_valid_o;
    logic              usr_ready_i = 1'b0;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    rd_realign #(.AXI_W(AXI_W), .USR_W(USR_W), .SIZE_W(SIZE_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
        .cmd_ofs_i(cmd_ofs_i), .cmd_bytes_i(cmd_bytes_i),
        .bus_data_i(bus_data_i), .bus_valid_i(bus_valid_i), .bus_ready_o(bus_ready_o),
        .usr_data_o(usr_data_o), .usr_valid_o(usr_valid_o), .usr_ready_i(usr_ready_i)
    );

    function automatic logic [7:0] byte_at(input int seed, input int idx);
        return 8'((seed * 37 + idx * 13 + 5) & 255);
    endfunction

    function automatic logic [AXI_W-1:0] beat_word(input int seed, input int n);
        logic [AXI_W-1:0] w;
        for (int i = 0; i < AXI_B; i++) w[8*i +: 8] = byte_at(seed, n * AXI_B + i);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one command end to end and checks data, counts, stalls and pokes.
    task automatic run_cmd(input int ofs, input int nbytes, input int seed,
                           input int bus_gap, input int usr_gap, input bit poke,
                           input string tag);
        int exp_w, exp_b, words, beats, cyc, tail;
        bit acc, stall, poke_taken;
        logic [USR_W-1:0] prev, expw;
        exp_w = (nbytes + USR_B - 1) / USR_B;
        exp_b = (nbytes == 0) ? 0 : (ofs + nbytes + AXI_B - 1) / AXI_B;
        words = 0; beats = 0; cyc = 0; tail = 0;
        acc = 0; stall = 0; poke_taken = 0; prev = '0;
        while (tail < 6 && cyc < 4000) begin
            @(negedge clk);
            cmd_valid_i = !acc || (poke && words < exp_w);
            cmd_ofs_i   = acc ? OFS_W'(ofs + 1) : OFS_W'(ofs);
            cmd_bytes_i = acc ? SIZE_W'(nbytes + 5) : SIZE_W'(nbytes);
            bus_valid_i = (bus_gap == 0) || (cyc % bus_gap != 0);
            bus_data_i  = beat_word(seed, beats);
            usr_ready_i = (usr_gap == 0) || (cyc % usr_gap != 0);
            #1;
            if (stall)
                check(usr_valid_o && usr_data_o == prev, "R7", {tag, " held word"},
                      longint'(usr_data_o), longint'(prev));
            if (cmd_valid_i && cmd_ready_o) begin
                if (acc) poke_taken = 1;
                acc = 1;
            end
            if (bus_valid_i && bus_ready_o) beats++;
            if (usr_valid_o && usr_ready_i) begin
                if (words >= exp_w) begin
                    check(0, "R4", {tag, " extra word"}, longint'(words + 1), longint'(exp_w));
                end else begin
                    expw = usr_data_o;
                    for (int b = 0; b < USR_B; b++)
                        if (words * USR_B + b < nbytes)
                            expw[8*b +: 8] = byte_at(seed, ofs + words * USR_B + b);
                    check(usr_data_o == expw, (words == 0) ? "R2" : "R3", {tag, " word data"},
                          longint'(usr_data_o), longint'(expw));
                end
                words++;
            end
            stall = usr_valid_o && !usr_ready_i;
            prev  = usr_data_o;
            if (acc && words >= exp_w) tail++;
            cyc++;
        end
        @(negedge clk);
        cmd_valid_i = 0; bus_valid_i = 0; usr_ready_i = 0;
        #1;
        check(words == exp_w, (nbytes == 0) ? "R9" : "R4", {tag, " word count"},
              longint'(words), longint'(exp_w));
        check(beats == exp_b, (nbytes == 0) ? "R9" : "R5", {tag, " beat count"},
              longint'(beats), longint'(exp_b));
        check(cmd_ready_o == 1'b1, "R8", {tag, " idle after command"},
              longint'(cmd_ready_o), 1);
        if (poke)
            check(!poke_taken, "R8", {tag, " command taken while busy"},
                  longint'(poke_taken), 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_ready_o == 1'b1, "R1", "cmd_ready in reset", longint'(cmd_ready_o), 1);
        check(bus_ready_o == 1'b0, "R1", "bus_ready in reset", longint'(bus_ready_o), 0);
        check(usr_valid_o == 1'b0, "R1", "usr_valid in reset", longint'(usr_valid_o), 0);
        rst_n = 1;
        @(negedge clk);
        check(cmd_ready_o && !bus_ready_o && !usr_valid_o, "R1", "idle after reset",
              longint'({cmd_ready_o, bus_ready_o, usr_valid_o}), 4);
    endtask

    task automatic t_aligned();
        run_cmd(0, 16, 1, 0, 0, 0, "aligned");
        run_cmd(0, 4, 2, 0, 0, 0, "aligned_one_beat");
    endtask

    task automatic t_offsets();
        for (int o = 1; o < AXI_B; o++) run_cmd(o, 7, 10 + o, 0, 0, 0, "offset_odd");
        run_cmd(2, 9, 20, 0, 0, 0, "offset_two");
    endtask

    task automatic t_tiny();
        run_cmd(3, 1, 30, 0, 0, 0, "single_byte");
        run_cmd(3, 2, 31, 0, 0, 0, "straddle_two");
        run_cmd(1, 3, 32, 0, 0, 0, "inside_beat");
    endtask

    task automatic t_backpressure();
        run_cmd(2, 21, 40, 2, 3, 0, "stall_mix");
        run_cmd(1, 13, 41, 0, 2, 0, "stall_user");
    endtask

    task automatic t_busy_poke();
        run_cmd(1, 10, 50, 3, 0, 1, "R8_poke");
    endtask

    task automatic t_zero();
        run_cmd(2, 0, 60, 0, 0, 0, "R9_zero");
    endtask

    task automatic t_back_to_back();
        run_cmd(3, 5, 70, 0, 0, 0, "R6_first");
        run_cmd(0, 4, 71, 0, 0, 0, "R6_second");
        run_cmd(1, 6, 72, 0, 0, 0, "R6_third");
    endtask

    task automatic t_long();
        run_cmd(1, 200, 80, 0, 0, 0, "long");
    endtask

    initial begin
        t_reset();
        t_aligned();
        t_offsets();
        t_tiny();
        t_backpressure();
        t_busy_poke();
        t_zero();
        t_back_to_back();
        t_long();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule